// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit sits in the integer stage of a 64-bit RISC pipeline. It handles the two bit-field instruction families, extract and insert. The decoder hands it three things: a three-bit operation select, the two five-bit position fields taken from the instruction word, and the operands. The operands are the source register value and, for insert, the current destination value. The unit works out the real bit positions of the field and checks them. It then builds the result and presents it, together with a write-enable and two fault flags, through a single output register with a valid/ready handshake.

There are eight variants, four for each family. The narrow form works on the low 32-bit word and sign-extends its result to 64 bits. The three wide forms map the five-bit fields onto six-bit positions in different ways:

- **full**: both positions are used as given.
- **mid**: 32 is added to the upper position only.
- **upper**: 32 is added to both positions.

When a position lands outside the register, the unit raises an undefined-result flag. When a wide form is issued while 64-bit operation is disabled, it raises a reserved-operation flag. When an insert has its positions in the wrong order, it simply does not write. In all three cases the write-enable stays low and the data output carries the destination operand unchanged.

Top module: `bfx_unit`

## Requirements
- R1: Operation select bit 2 picks insert (1) or extract (0), and bits 1:0 pick the form: 0 narrow, 1 full, 2 mid, 3 upper. Full extract returns source bits lsb..lsb+size, right-justified and zero-filled, with write-enable high.
- R2: Mid extract takes the field from bit lsb up to bit lsb+size+32. Upper extract takes it from bit lsb+32 up to bit lsb+size+32. Both return it right-justified and zero-filled.
- R3: Narrow extract takes bits lsb..lsb+size of the low word and sign-extends bit 31 of the 32-bit result into bits 63:32.
- R4: The wide inserts replace destination bits lo..hi with the source shifted left by lo and keep every other destination bit. Full uses lo=lsb and hi=msb. Mid uses lo=lsb and hi=msb+32. Upper uses lo=lsb+32 and hi=msb+32.
- R5: An insert whose lower position exceeds its upper position drives write-enable low, leaves both flags low, and outputs the destination operand unchanged.
- R6: Narrow insert merges under a 32-bit mask from lsb to msb and sign-extends bit 31 of the merged low word into bits 63:32.
- R7: A wide form (select bits 1:0 non-zero) issued with the wide-enable input low raises the reserved flag, drives write-enable low and outputs the destination operand. Narrow forms are unaffected by wide-enable.
- R8: An extract whose upper position exceeds 63 (31 for the narrow form) raises the undefined flag, drives write-enable low and outputs the destination operand. The position never wraps.
- R9: The output register keeps its contents while valid is high and ready is low. The input ready signal equals "output not valid, or output ready", and an accepted operation appears on the output in the next cycle.
- R10: During reset the output valid signal is low and the input ready signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when valid is also high |
| in_op | input | 3 | Operation select: bit 2 insert, bits 1:0 form |
| in_pos_hi | input | 5 | Size field (extract) or msb field (insert) |
| in_pos_lo | input | 5 | lsb field |
| in_src | input | 64 | Source register value |
| in_dst | input | 64 | Current destination register value |
| wide_en | input | 1 | 64-bit operation enabled |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result, or destination operand when not writing |
| out_we | output | 1 | Destination write-enable |
| out_resv | output | 1 | Reserved-operation flag |
| out_undef | output | 1 | Undefined-result flag |

## Verification
The assertions assume that the consumer never depends on out_data while out_valid is low. They also assume that in_op, the positions and the operands are sampled only on cycles where in_valid and in_ready are both high, so a change in operands during a stall must not matter. The stimulus keeps to this. It changes inputs only between clock edges, drops out_ready at random to create holds, and spends most cycles with wide_en high. Directed cases reach the exact position boundaries: top bit 63, top bit 31, and lo equal to hi+1.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [1:0] {
    FORM_W32  = 2'd0,
    FORM_FULL = 2'd1,
    FORM_MID  = 2'd2,
    FORM_UPR  = 2'd3
  } bfx_form_e;

  typedef struct packed {
    logic      ins;
    bfx_form_e form;
  } bfx_op_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
#(
  parameter int DW = 64,
  parameter int PW = 5,
  localparam int CW = $clog2(DW) + 2
) (
  input  bfx_op_t          op,
  input  logic [PW-1:0]    pos_hi,
  input  logic [PW-1:0]    pos_lo,
  input  logic             wide_en,
  output logic [CW-1:0]    lo_bit,
  output logic [CW-1:0]    hi_bit,
  output logic             resv,
  output logic             undef,
  output logic             order_ok,
  output logic             we
);
  localparam int HALF = DW / 2;

  logic          hi_off;
  logic [CW-1:0] limit;

  always_comb begin
    hi_off   = (op.form == FORM_MID) || (op.form == FORM_UPR);
    lo_bit   = CW'(pos_lo) + ((op.form == FORM_UPR) ? CW'(HALF) : CW'(0));
    hi_bit   = CW'(pos_hi) + (hi_off ? CW'(HALF) : CW'(0))
             + (op.ins ? CW'(0) : CW'(pos_lo));
    limit    = (op.form == FORM_W32) ? CW'(HALF - 1) : CW'(DW - 1);
    resv     = (op.form != FORM_W32) && !wide_en;
    undef    = !op.ins && (hi_bit > limit);
    order_ok = lo_bit <= hi_bit;
    we       = !resv && !undef && (!op.ins || order_ok);
  end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath #(
  parameter int DW = 64,
  localparam int CW = $clog2(DW) + 2
) (
  input  logic          ins,
  input  logic          narrow,
  input  logic          we,
  input  logic [CW-1:0] lo_bit,
  input  logic [CW-1:0] hi_bit,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] res
);
  localparam int HALF = DW / 2;

  // ones in bit positions lo..hi inclusive; meaningful only for lo <= hi < DW
  function automatic logic [DW-1:0] span_mask(input logic [CW-1:0] hi,
                                               input logic [CW-1:0] lo);
    return ({DW{1'b1}} << lo) & ({DW{1'b1}} >> (CW'(DW - 1) - hi));
  endfunction

  function automatic logic [DW-1:0] sext_half(input logic [DW-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  function automatic logic [DW-1:0] pull_field(input logic [DW-1:0] s,
                                               input logic [CW-1:0] hi,
                                               input logic [CW-1:0] lo);
    return (s >> lo) & span_mask(hi - lo, CW'(0));
  endfunction

  function automatic logic [DW-1:0] merge_field(input logic [DW-1:0] s,
                                                input logic [DW-1:0] d,
                                                input logic [CW-1:0] hi,
                                                input logic [CW-1:0] lo);
    return d ^ ((d ^ (s << lo)) & span_mask(hi, lo));
  endfunction

  logic [DW-1:0] raw;

  always_comb begin
    raw = ins ? merge_field(src, dst, hi_bit, lo_bit)
              : pull_field(src, hi_bit, lo_bit);
    if (!we)          res = dst;
    else if (narrow)  res = sext_half(raw);
    else              res = raw;
  end
endmodule

// File: rtl/bfx_outreg.sv
module bfx_outreg #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d_data,
  input  logic          d_we,
  input  logic          d_resv,
  input  logic          d_undef,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_we,
  output logic          out_resv,
  output logic          out_undef
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
      out_resv  <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= d_data;
        out_we    <= d_we;
        out_resv  <= d_resv;
        out_undef <= d_undef;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_we)
                                && $stable(out_resv) && $stable(out_undef));

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DW = 64,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [PW-1:0] in_pos_hi,
  input  logic [PW-1:0] in_pos_lo,
  input  logic [DW-1:0] in_src,
  input  logic [DW-1:0] in_dst,
  input  logic          wide_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_we,
  output logic          out_resv,
  output logic          out_undef
);
  localparam int CW = $clog2(DW) + 2;

  bfx_op_t       op;
  logic [CW-1:0] lo_bit, hi_bit;
  logic          dec_resv, dec_undef, dec_order_ok, dec_we;
  logic [DW-1:0] dp_res;

  assign op = bfx_op_t'(in_op);

  bfx_decode #(.DW(DW), .PW(PW)) u_dec (
    .op(op), .pos_hi(in_pos_hi), .pos_lo(in_pos_lo), .wide_en(wide_en),
    .lo_bit(lo_bit), .hi_bit(hi_bit), .resv(dec_resv), .undef(dec_undef),
    .order_ok(dec_order_ok), .we(dec_we)
  );

  bfx_datapath #(.DW(DW)) u_dp (
    .ins(op.ins), .narrow(op.form == FORM_W32), .we(dec_we),
    .lo_bit(lo_bit), .hi_bit(hi_bit), .src(in_src), .dst(in_dst), .res(dp_res)
  );

  bfx_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_data(dp_res), .d_we(dec_we), .d_resv(dec_resv), .d_undef(dec_undef),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we), .out_resv(out_resv), .out_undef(out_undef)
  );

  // R7
  resv_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_resv |-> !out_we);

  // R8
  undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_we);

  // R5
  bad_order_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op.ins && !dec_order_ok |-> !dec_we && dp_res == in_dst);

  // R8
  extract_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op.ins && !dec_undef |-> hi_bit < CW'(DW));
endmodule

// File: tb/bfx_unit_test.sv
`timescale 1ns/1ps
module bfx_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [2:0]  in_op;
  logic [4:0]  in_pos_hi, in_pos_lo;
  logic [63:0] in_src, in_dst;
  logic        wide_en;
  logic        out_valid, out_ready;
  logic [63:0] out_data;
  logic        out_we, out_resv, out_undef;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] q_data[$];
  bit          q_we[$], q_rv[$], q_un[$];
  string       q_tag[$];

  bit          prev_hold = 0;
  logic [63:0] prev_data;

  always #2 clk = ~clk;

  bfx_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_pos_hi(in_pos_hi), .in_pos_lo(in_pos_lo),
    .in_src(in_src), .in_dst(in_dst), .wide_en(wide_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we), .out_resv(out_resv), .out_undef(out_undef)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model, bit by bit
  task automatic model(input logic [2:0] op, input logic [4:0] a, input logic [4:0] l,
                       input logic [63:0] s, input logic [63:0] d, input bit wide,
                       output logic [63:0] r, output bit we, output bit rv,
                       output bit un, output string tag);
    int lo, hi, lim;
    bit ins;
    int f;
    ins = op[2];
    f   = int'(op[1:0]);
    lo  = int'(l) + ((f == 3) ? 32 : 0);
    hi  = int'(a) + ((f >= 2) ? 32 : 0) + (ins ? 0 : int'(l));
    lim = (f == 0) ? 31 : 63;
    rv  = (f != 0) && !wide;
    un  = !ins && (hi > lim);
    we  = !rv && !un && (!ins || lo <= hi);
    r   = d;
    if (we) begin
      if (!ins) begin
        r = '0;
        for (int i = 0; i <= hi - lo; i++) r[i] = s[lo + i];
      end else begin
        for (int i = lo; i <= hi; i++) r[i] = s[i - lo];
      end
      if (f == 0) for (int i = 32; i < 64; i++) r[i] = r[31];
    end
    if (rv)               tag = "R7";
    else if (un)          tag = "R8";
    else if (ins && !we)  tag = "R5";
    else if (ins && f==0) tag = "R6";
    else if (ins)         tag = "R4";
    else if (f == 0)      tag = "R3";
    else if (f >= 2)      tag = "R2";
    else                  tag = "R1";
  endtask

  task automatic observe();
    logic [63:0] r;
    bit we, rv, un;
    string tag;
    check(in_ready == (!out_valid || out_ready), "R9", "in_ready",
          64'(in_ready), 64'(!out_valid || out_ready));
    if (prev_hold)
      check(out_valid && out_data == prev_data, "R9", "held data",
            out_data, prev_data);
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R9", "unexpected output", out_data, 64'h0);
      end else begin
        tag = q_tag.pop_front();
        r = q_data.pop_front();
        we = q_we.pop_front(); rv = q_rv.pop_front(); un = q_un.pop_front();
        check(out_data == r, tag, "data", out_data, r);
        check({out_we, out_resv, out_undef} == {we, rv, un}, tag, "we/resv/undef",
              64'({out_we, out_resv, out_undef}), 64'({we, rv, un}));
      end
    end
    if (in_valid && in_ready) begin
      model(in_op, in_pos_hi, in_pos_lo, in_src, in_dst, wide_en, r, we, rv, un, tag);
      q_data.push_back(r); q_we.push_back(we); q_rv.push_back(rv);
      q_un.push_back(un); q_tag.push_back(tag);
    end
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
  endtask

  task automatic cycle(input bit v, input logic [2:0] op, input logic [4:0] a,
                       input logic [4:0] l, input logic [63:0] s, input logic [63:0] d,
                       input bit wide, input bit rdy);
    @(negedge clk);
    in_valid = v; in_op = op; in_pos_hi = a; in_pos_lo = l;
    in_src = s; in_dst = d; wide_en = wide; out_ready = rdy;
    #1;
    observe();
  endtask

  // issue one op and wait until it is taken
  task automatic issue(input logic [2:0] op, input logic [4:0] a, input logic [4:0] l,
                       input logic [63:0] s, input logic [63:0] d, input bit wide);
    cycle(1'b1, op, a, l, s, d, wide, 1'b1);
  endtask

  localparam logic [63:0] S0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] D0 = 64'hFEDC_BA98_7654_3210;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_op = '0;
    in_pos_hi = '0; in_pos_lo = '0; in_src = '0; in_dst = '0; wide_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R10", "out_valid in reset", 64'(out_valid), 64'h0);
    check(in_ready,   "R10", "in_ready in reset",  64'(in_ready),  64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 full extract
    issue(3'b001, 5'd7,  5'd4,  S0, D0, 1'b1);
    // R2 mid reaching bit 63, then past it (R8)
    issue(3'b010, 5'd3,  5'd28, S0, D0, 1'b1);
    issue(3'b010, 5'd10, 5'd28, S0, D0, 1'b1);
    // R2 upper whole high word, then past bit 63 (R8)
    issue(3'b011, 5'd31, 5'd0,  S0, D0, 1'b1);
    issue(3'b011, 5'd5,  5'd30, S0, D0, 1'b1);
    // R3 narrow extract with sign bit set, then above bit 31 (R8)
    issue(3'b000, 5'd31, 5'd0,  64'h0000_0000_8000_0001, D0, 1'b1);
    issue(3'b000, 5'd10, 5'd25, S0, D0, 1'b1);
    // R4 inserts
    issue(3'b101, 5'd15, 5'd8,  S0, D0, 1'b1);
    issue(3'b110, 5'd0,  5'd31, S0, D0, 1'b1);
    issue(3'b111, 5'd31, 5'd0,  S0, D0, 1'b1);
    // R5 reversed positions, lo = hi + 1
    issue(3'b101, 5'd8,  5'd9,  S0, D0, 1'b1);
    issue(3'b111, 5'd3,  5'd4,  S0, D0, 1'b1);
    // R6 narrow insert pushing a one into bit 31
    issue(3'b100, 5'd31, 5'd16, 64'h0000_0000_0000_8000, D0, 1'b1);
    // R7 wide forms with 64-bit operation off; narrow forms still write
    issue(3'b001, 5'd7,  5'd4,  S0, D0, 1'b0);
    issue(3'b110, 5'd7,  5'd4,  S0, D0, 1'b0);
    issue(3'b100, 5'd7,  5'd4,  S0, D0, 1'b0);
    issue(3'b000, 5'd7,  5'd4,  S0, D0, 1'b0);
    // R9 random traffic with back-pressure
    for (int n = 0; n < 3000; n++) begin
      cycle(($urandom % 4) != 0, 3'($urandom), 5'($urandom), 5'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom},
            ($urandom % 10) != 0, ($urandom % 3) != 0);
    end
    for (int n = 0; n < 8; n++) cycle(1'b0, 3'b0, 5'd0, 5'd0, S0, D0, 1'b1, 1'b1);
    check(q_data.size() == 0, "R9", "results left undelivered",
          64'(q_data.size()), 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule